// File: doc/BRIEF.md
# Fabric-to-Host Byte Source Endpoint

This block is the sending end of one logical channel on a shared bridge bus that moves bytes from fabric logic to a host. The bridge broadcasts the address of the channel the host wants to read, a one-cycle start pulse and a byte count. When the broadcast address equals this endpoint's static address, the endpoint raises a write-request to the user logic. It then takes one 8-bit byte from the user logic on every interface clock edge while the request is high, and places each byte on a return bus. The return bus is all zeros whenever the endpoint is not addressed, so the bridge can OR the return buses of many endpoints together.

The user logic can hold the transfer with a pause input. The bridge holds it with a stall input when its downstream buffer (2048 bytes) has no room left. Both holds work the same way. The byte presented on the edge where the hold is first seen is still taken. After that edge no byte is taken until the hold is released. Once it is released, the request rises again after the next edge and the byte after that is due on the edge that follows.

The controller has three states. **IDLE** waits for a start. **STREAM** has write-request high and takes a byte on every edge. **HOLD** has a transfer open but write-request low. The transitions are:
- *accept*: IDLE to STREAM on an addressed start with no hold.
- *accept-held*: IDLE to HOLD on an addressed start while a hold is present.
- *finish*: STREAM to IDLE on the edge that takes the last byte.
- *suspend*: STREAM to HOLD on an edge where a hold is seen and more bytes remain.
- *resume*: HOLD to STREAM when both holds are low.
- In every other case the state stays where it is.

Top module: `ep_src_top`

## Requirements
- R1: After reset, `wr_req` is low and `ret_bus` is all zeros.
- R2: A `start` pulse with `sel_addr` equal to `my_addr`, a nonzero `req_len` and no hold makes `wr_req` high from the next cycle. A byte is taken from `din` on every rising edge at which `wr_req` is high.
- R3: A byte taken at an edge appears on `ret_bus` during the following cycle. In that cycle bit 8 of `ret_bus` is 1 and bits 7:0 hold the byte. In a cycle that follows no capture, `ret_bus` is all zeros.
- R4: Exactly `req_len` bytes are taken per transfer, for any value from 1 to 2047. `wr_req` falls on the edge that takes the last byte.
- R5: If `pause` is high at an edge where `wr_req` is high and bytes remain, that edge still takes a byte. `wr_req` is then low and no further byte is taken while `pause` stays high.
- R6: When `pause` is low at an edge during a held transfer, `wr_req` is high after that edge and the next byte is taken at the edge after it.
- R7: If `pause` is already high when the addressed start arrives, the transfer is accepted but `wr_req` stays low until `pause` is released.
- R8: `sink_stall` (downstream buffer has no room) acts exactly like `pause`, and the two are combined as an OR.
- R9: While `sel_addr` differs from `my_addr`, `ret_bus` is all zeros, and a `start` sent to another address starts nothing.
- R10: A start with `req_len` of zero is ignored. A start that arrives during an open transfer is ignored, and the open transfer keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | 7 | Static address of this endpoint |
| sel_addr | input | 7 | Address the bridge currently selects |
| start | input | 1 | One-cycle request start from the bridge |
| req_len | input | 11 | Number of bytes requested, sampled with `start` |
| sink_stall | input | 1 | Downstream buffer has no room left |
| pause | input | 1 | Hold request from the user logic |
| din | input | 8 | Byte from the user logic |
| wr_req | output | 1 | Byte is due from the user logic on the next edge |
| ret_bus | output | 9 | {valid, byte} to the OR-combined return bus |

## Verification
Some properties are checked on every cycle. A captured byte must reappear on the return bus one cycle later. The return bus must be silent after a cycle without capture and whenever the endpoint is not addressed. A hold seen while streaming must drop the request, and so must the last byte. Other behaviour can only be shown by whole scenarios from the bench. These are the exact per-transfer byte total under random pause and stall patterns, the holds that begin before a request, the starts that are ignored, and the longest count.

// File: rtl/ep_src_pkg.sv
package ep_src_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_HOLD   = 2'd2
    } ep_state_t;
endpackage

// File: rtl/ep_src_match.sv
module ep_src_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] my_addr,
    input  logic [AW-1:0] sel_addr,
    output logic          hit
);
    always_comb hit = (my_addr == sel_addr);
endmodule

// File: rtl/ep_src_count.sv
module ep_src_count #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          dec,
    output logic [CW-1:0] left,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= len;
        else if (dec && left != '0)
            left <= left - ONE;
    end

    always_comb last = (left == ONE);
endmodule

// File: rtl/ep_src_fsm.sv
module ep_src_fsm
    import ep_src_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  logic      hold,
    input  logic      last,
    output ep_state_t state,
    output logic      wr_req,
    output logic      cap,
    output logic      load
);
    ep_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = hold ? ST_HOLD : ST_STREAM;
            ST_STREAM: begin
                if (last)      nxt = ST_IDLE;
                else if (hold) nxt = ST_HOLD;
            end
            ST_HOLD:   if (!hold) nxt = ST_STREAM;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_req = (state == ST_STREAM);
        cap    = wr_req;
        load   = (state == ST_IDLE) && go;
    end
endmodule

// File: rtl/ep_src_ret.sv
module ep_src_ret #(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap,
    input  logic [DW-1:0] din,
    input  logic        hit,
    output logic [DW:0] ret_bus
);
    logic [DW:0] ret_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   ret_q <= '0;
        else if (cap) ret_q <= {1'b1, din};
        else          ret_q <= '0;
    end

    always_comb ret_bus = hit ? ret_q : '0;
endmodule

// File: rtl/ep_src_top.sv
module ep_src_top
    import ep_src_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] my_addr,
    input  logic [AW-1:0] sel_addr,
    input  logic          start,
    input  logic [CW-1:0] req_len,
    input  logic          sink_stall,
    input  logic          pause,
    input  logic [DW-1:0] din,
    output logic          wr_req,
    output logic [DW:0]   ret_bus
);
    logic          hit, go, hold, last, cap, load;
    logic [CW-1:0] left_cnt;
    ep_state_t     state;

    always_comb begin
        go   = start && hit && (req_len != '0);
        hold = pause || sink_stall;
    end

    ep_src_match #(.AW(AW)) u_match (
        .my_addr(my_addr), .sel_addr(sel_addr), .hit(hit)
    );

    ep_src_count #(.CW(CW)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .len(req_len),
        .dec(cap), .left(left_cnt), .last(last)
    );

    ep_src_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .hold(hold), .last(last),
        .state(state), .wr_req(wr_req), .cap(cap), .load(load)
    );

    ep_src_ret #(.DW(DW)) u_ret (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(din), .hit(hit),
        .ret_bus(ret_bus)
    );
endmodule

// File: rtl/ep_src_chk.sv
module ep_src_chk #(
    parameter int AW = 7,
    parameter int DW = 8,
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] my_addr,
    input logic [AW-1:0] sel_addr,
    input logic          pause,
    input logic          sink_stall,
    input logic [DW-1:0] din,
    input logic          wr_req,
    input logic [DW:0]   ret_bus,
    input logic [CW-1:0] left_cnt
);
    // R9
    quiet_when_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_addr != my_addr) |-> (ret_bus == '0));

    // R3
    byte_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && $stable(sel_addr) && sel_addr == my_addr) |=>
        (sel_addr != my_addr) || (ret_bus == {1'b1, $past(din)}));

    // R3
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (ret_bus == '0));

    // R5
    hold_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (pause || sink_stall)) |=> !wr_req);

    // R4
    last_byte_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && left_cnt == CW'(1)) |=> !wr_req);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_req && ret_bus == '0));
endmodule

bind ep_src_top ep_src_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .sel_addr(sel_addr),
    .pause(pause), .sink_stall(sink_stall), .din(din), .wr_req(wr_req),
    .ret_bus(ret_bus), .left_cnt(left_cnt)
);

// File: tb/sim_ep_src_top.sv
module sim_ep_src_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] MY = 7'h2A;
    localparam logic [6:0] OTHER = 7'h15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  sel_addr;
    logic        start, sink_stall, pause;
    logic [10:0] req_len;
    logic [7:0]  din;
    logic        wr_req;
    logic [8:0]  ret_bus;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit        m_act, m_wr;
    int        m_left;
    logic [8:0] m_ret;
    int        obs_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_src_top u0 (
        .clk(clk), .rst_n(rst_n), .my_addr(MY), .sel_addr(sel_addr),
        .start(start), .req_len(req_len), .sink_stall(sink_stall),
        .pause(pause), .din(din), .wr_req(wr_req), .ret_bus(ret_bus)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(string tag, bit st, int len, bit ps, bit sl, logic [6:0] sa);
        bit go, hold;
        start = st; req_len = 11'(len); pause = ps; sink_stall = sl;
        sel_addr = sa; din = 8'($urandom);
        @(posedge clk);
        go   = st && (sa == MY) && (len != 0);
        hold = ps || sl;
        m_ret = m_wr ? {1'b1, din} : 9'h0;
        if (!m_act) begin
            if (go) begin m_act = 1; m_left = len; m_wr = !hold; end
        end else if (m_wr) begin
            m_left--;
            if (m_left == 0) begin m_act = 0; m_wr = 0; end
            else m_wr = !hold;
        end else begin
            m_wr = !hold;
        end
        @(negedge clk);
        check({tag, " wr_req"}, wr_req, m_wr);
        check({tag, " ret_bus"}, ret_bus, (sa == MY) ? m_ret : 9'h0);
        if (ret_bus[8]) obs_cnt++;
    endtask

    task automatic run_xfer(string tag, int len, int p_pct, int s_pct, bit pre_pause);
        obs_cnt = 0;
        step(tag, 1, len, pre_pause, 0, MY);
        while (m_act)
            step(tag, 0, 0, ($urandom % 100) < p_pct, ($urandom % 100) < s_pct, MY);
        step(tag, 0, 0, 0, 0, MY);
        check({tag, " R4 byte total"}, obs_cnt, len);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; start = 0; req_len = 0; pause = 0; sink_stall = 0;
        sel_addr = MY; din = 0;
        m_act = 0; m_wr = 0; m_left = 0; m_ret = 0; obs_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 wr_req after reset", wr_req, 0);
        check("R1 ret_bus after reset", ret_bus, 0);
        rst_n = 1;

        // R9: start for another address starts nothing
        step("R9 foreign start", 1, 5, 0, 0, OTHER);
        for (int i = 0; i < 3; i++) step("R9 foreign idle", 0, 0, 0, 0, OTHER);
        // R10: zero length ignored
        step("R10 zero len", 1, 0, 0, 0, MY);
        step("R10 zero len idle", 0, 0, 0, 0, MY);
        check("R10 no capture after zero len", obs_cnt, 0);

        // R2/R3/R4: plain transfer, one byte and several bytes
        run_xfer("R2 single byte", 1, 0, 0, 0);
        run_xfer("R2 plain burst", 9, 0, 0, 0);

        // R7: pause held before start, released later
        obs_cnt = 0;
        step("R7 start under pause", 1, 4, 1, 0, MY);
        for (int i = 0; i < 3; i++) step("R7 still paused", 0, 0, 1, 0, MY);
        check("R7 no capture while pre-paused", obs_cnt, 0);
        while (m_act) step("R6 resume", 0, 0, 0, 0, MY);
        step("R6 tail", 0, 0, 0, 0, MY);
        check("R7 byte total", obs_cnt, 4);

        // R5/R6: pause mid stream, trailing byte then silence
        obs_cnt = 0;
        step("R5 start", 1, 6, 0, 0, MY);
        step("R5 first byte", 0, 0, 0, 0, MY);
        step("R5 pause edge", 0, 0, 1, 0, MY);
        step("R5 paused", 0, 0, 1, 0, MY);
        step("R5 paused", 0, 0, 1, 0, MY);
        check("R5 one trailing byte then none", obs_cnt, 2);
        while (m_act) step("R6 resume", 0, 0, 0, 0, MY);
        step("R6 tail", 0, 0, 0, 0, MY);
        check("R5 byte total", obs_cnt, 6);

        // R10: start during open transfer ignored
        obs_cnt = 0;
        step("R10 start", 1, 5, 0, 0, MY);
        step("R10 restart ignored", 1, 100, 0, 0, MY);
        while (m_act) step("R10 run", 0, 0, 0, 0, MY);
        step("R10 tail", 0, 0, 0, 0, MY);
        check("R10 count kept", obs_cnt, 5);

        // R9: address moves away mid-transfer, bus silent
        step("R9 start", 1, 6, 0, 0, MY);
        for (int i = 0; i < 3; i++) step("R9 away", 0, 0, 0, 0, OTHER);
        while (m_act) step("R9 back", 0, 0, 0, 0, MY);
        step("R9 tail", 0, 0, 0, 0, MY);

        // R8: stall alone
        run_xfer("R8 stall only", 20, 0, 40, 0);

        // random pause/stall mixes
        for (int t = 0; t < 40; t++)
            run_xfer("R5 R8 random", 1 + ($urandom % 60), $urandom % 60, $urandom % 30,
                     ($urandom % 4) == 0);

        // R4: longest count
        run_xfer("R4 max length", 2047, 10, 5, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule